// File: doc/BRIEF.md
# Peripheral Interrupt Flag Controller

This block gathers the interrupt conditions of a peripheral adapter into one status word. Each source delivers a single-cycle set pulse, and that pulse latches a sticky flag. A companion mask word holds one enable bit per source. The processor reaches both words over a small register bus. It can read the flags, acknowledge them by writing ones, and set or clear individual enable bits without touching the others.

The top bit of the flag word is not stored. It is computed from the flags and the mask together. It reads as one whenever at least one enabled source is pending, so a service routine can poll several devices with one read each. The same term drives an active-low request line through a register, so the line never glitches.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While reset is high, and after it is released, all flags and all enables are zero, `irq_n` is 1, the flag word (`bus_addr`=0) reads 0x00 and the mask word (`bus_addr`=1) reads 0x80.
- R2: A 1 on `src_set[i]` at a clock edge makes flag bit i (bit positions 6..0 of the flag word) read 1 after that edge, and the flag stays 1 until it is cleared.
- R3: A write to the flag word clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged; data bit 7 of that write has no effect.
- R4: If a set pulse and a clearing write hit the same flag at the same edge, the flag ends up set.
- R5: A write to the mask word with data bit 7 = 1 sets each enable whose data bit (6..0) is 1; with bit 7 = 0 it clears those enables; enables whose data bit is 0 keep their value.
- R6: Bit 7 of the flag word reads 1 exactly when some flag and its enable are both 1, in the same cycle as that state; bit 7 of the mask word always reads 1.
- R7: `irq_n` is a register: one edge after the flag-and-enable overlap becomes nonzero it drives 0, and one edge after the overlap becomes zero it returns to 1.
- R8: A flag whose enable is 0 still latches and reads back, but it neither raises the summary bit nor pulls `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_set | input | 7 | Per-source set pulses, one bit per flag |
| bus_addr | input | 1 | Word select: 0 = flag word, 1 = mask word |
| bus_we | input | 1 | Write strobe for the selected word |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected word, combinational |
| irq_n | output | 1 | Registered interrupt request, active low |

## Verification
Two events can land on a flag at the same edge: a source set pulse and a processor write that acknowledges the flag. The bench first drives every flag high. It then pulses one source in the very cycle it writes all-ones to the flag word. It expects only that source's flag to survive, and the summary bit to follow it. Outside that collision, the bench runs all 128 enable masks against all 128 flag patterns. For each pair it derives the expected flag word, the summary bit, the partial-clear result and the request timing by arithmetic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic {
        SEL_FLAGS   = 1'b0,
        SEL_ENABLES = 1'b1
    } reg_sel_e;

    typedef enum logic {
        EN_CLEAR = 1'b0,
        EN_SET   = 1'b1
    } en_action_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } bus_ctl_t;

    function automatic logic is_write_to(input bus_ctl_t c, input reg_sel_e target);
        return c.wr && (c.sel == target);
    endfunction

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_pulse,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] flags
);

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (set_pulse[i]) begin
                bit_q <= 1'b1;      // set outranks a same-cycle clear
            end else if (clr_wr && clr_mask[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign flags[i] = bit_q;
    end

endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank
    import irqc_pkg::*;
#(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  en_action_e      action,
    input  logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] enables
);

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (wr) begin
            unique case (action)
                EN_SET:   en_d = en_q | mask;
                EN_CLEAR: en_d = en_q & ~mask;
                default:  en_d = en_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign enables = en_q;

endmodule

// File: rtl/irqc_req_out.sv
module irqc_req_out #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] enables,
    output logic            pending,
    output logic            irq_n
);

    logic req_n_q;

    assign pending = |(flags & enables);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_n_q <= 1'b1;
        end else begin
            req_n_q <= ~pending;
        end
    end

    assign irq_n = req_n_q;

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int NSRC = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NSRC-1:0] src_set,
    input  logic          bus_addr,
    input  logic          bus_we,
    input  logic [NSRC:0] bus_wdata,
    output logic [NSRC:0] bus_rdata,
    output logic          irq_n
);

    localparam int DW = NSRC + 1;

    bus_ctl_t        ctl;
    logic            flag_clr_wr;
    logic            en_wr;
    en_action_e      en_act;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;
    logic            pending;

    assign ctl.wr  = bus_we;
    assign ctl.sel = reg_sel_e'(bus_addr);

    assign flag_clr_wr = is_write_to(ctl, SEL_FLAGS);
    assign en_wr       = is_write_to(ctl, SEL_ENABLES);
    assign en_act      = en_action_e'(bus_wdata[DW-1]);

    irqc_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (src_set),
        .clr_wr    (flag_clr_wr),
        .clr_mask  (bus_wdata[NSRC-1:0]),
        .flags     (flag_q)
    );

    irqc_enable_bank #(.NSRC(NSRC)) u_enables (
        .clk     (clk),
        .rst     (rst),
        .wr      (en_wr),
        .action  (en_act),
        .mask    (bus_wdata[NSRC-1:0]),
        .enables (en_q)
    );

    irqc_req_out #(.NSRC(NSRC)) u_req (
        .clk     (clk),
        .rst     (rst),
        .flags   (flag_q),
        .enables (en_q),
        .pending (pending),
        .irq_n   (irq_n)
    );

    always_comb begin
        unique case (ctl.sel)
            SEL_FLAGS:   bus_rdata = {pending, flag_q};
            SEL_ENABLES: bus_rdata = {1'b1, en_q};
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NSRC = 7
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] src_set,
    input logic            bus_addr,
    input logic            bus_we,
    input logic [NSRC:0]   bus_wdata,
    input logic [NSRC:0]   bus_rdata,
    input logic [NSRC-1:0] flags,
    input logic [NSRC-1:0] enables,
    input logic            irq_n
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (flags == '0 && enables == '0 && irq_n));

    assert_set_latches_R2: assert property (@(posedge clk) disable iff (rst)
        (src_set != '0) |=> ((flags & $past(src_set)) == $past(src_set)));

    assert_write_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !bus_addr) |=>
            ((flags & $past(bus_wdata[NSRC-1:0] & ~src_set)) == '0));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !bus_addr && ((bus_wdata[NSRC-1:0] & src_set) != '0)) |=>
            ((flags & $past(bus_wdata[NSRC-1:0] & src_set)) ==
             $past(bus_wdata[NSRC-1:0] & src_set)));

    assert_enable_set_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr && bus_wdata[NSRC]) |=>
            ((enables & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    assert_enable_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr && !bus_wdata[NSRC]) |=>
            ((enables & $past(bus_wdata[NSRC-1:0])) == '0));

    assert_summary_bit_R6: assert property (@(posedge clk) disable iff (rst)
        !bus_addr |-> (bus_rdata[NSRC] == ((flags & enables) != '0)));

    assert_mask_msb_R6: assert property (@(posedge clk) disable iff (rst)
        bus_addr |-> bus_rdata[NSRC]);

    assert_req_low_R7: assert property (@(posedge clk) disable iff (rst)
        ((flags & enables) != '0) |=> !irq_n);

    assert_req_high_R7: assert property (@(posedge clk) disable iff (rst)
        ((flags & enables) == '0) |=> irq_n);

endmodule

bind irq_flag_ctrl irqc_checker #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_set   (src_set),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .flags     (flag_q),
    .enables   (en_q),
    .irq_n     (irq_n)
);

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] src_set = '0;
    logic       bus_addr = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int  n_vec  = 0;
    int  n_miss = 0;
    bit  done   = 1'b0;

    irq_flag_ctrl #(.NSRC(7)) dut (
        .clk       (clk),
        .rst       (rst),
        .src_set   (src_set),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [6:0] m;
        logic [6:0] left;
        logic       hit;

        // R1: state during and after reset
        repeat (3) @(negedge clk);
        #1;
        bus_addr = 1'b0; #1 chk("R1 flags in reset", bus_rdata, 8'h00);
        bus_addr = 1'b1; #1 chk("R1 mask in reset", bus_rdata, 8'h80);
        chk("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
        rst = 1'b0;
        @(negedge clk); #1;
        bus_addr = 1'b0; #1 chk("R1 flags after reset", bus_rdata, 8'h00);
        chk("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

        // Sweep every mask against every flag pattern: R2 R3 R5 R6 R7 R8
        for (int e = 0; e < 128; e++) begin
            wr(1'b1, 8'h7F);
            wr(1'b1, 8'h80 | 8'(e));
            bus_addr = 1'b1; #1;
            chk("R5 mask readback", bus_rdata, 8'h80 | 8'(e));
            for (int f = 0; f < 128; f++) begin
                hit = ((f & e) != 0);
                src_set = 7'(f);
                @(negedge clk);
                src_set = '0;
                bus_addr = 1'b0; #1;
                chk("R2 R6 R8 flag word", bus_rdata, {hit, 7'(f)});
                chk("R7 irq_n before latency", {7'd0, irq_n}, 8'h01);
                @(negedge clk); #1;
                chk("R7 R8 irq_n after latency", {7'd0, irq_n}, {7'd0, ~hit});
                m    = 7'((f * 37 + e * 11) & 127);
                left = 7'(f) & ~m;
                wr(1'b0, {f[0], m});
                #1;
                chk("R3 partial clear", bus_rdata, {((left & 7'(e)) != 0), left});
                wr(1'b0, 8'hFF);
                #1;
                chk("R3 full clear", bus_rdata, 8'h00);
                @(negedge clk); #1;
                chk("R7 irq_n release", {7'd0, irq_n}, 8'h01);
            end
        end

        // R5: partial set and clear leave other enables alone
        wr(1'b1, 8'hFF);
        wr(1'b1, 8'h05);
        bus_addr = 1'b1; #1;
        chk("R5 clear keeps others", bus_rdata, 8'hFA);
        wr(1'b1, 8'h81);
        bus_addr = 1'b1; #1;
        chk("R5 set keeps others", bus_rdata, 8'hFB);

        // R4: set pulse and clearing write on the same edge
        wr(1'b1, 8'hFF);
        src_set = 7'h7F;
        @(negedge clk);
        src_set   = 7'h08;
        bus_addr  = 1'b0;
        bus_we    = 1'b1;
        bus_wdata = 8'h7F;
        @(negedge clk);
        src_set   = '0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        #1;
        chk("R4 set wins over clear", bus_rdata, 8'h88);
        @(negedge clk); #1;
        chk("R4 R7 irq_n held low", {7'd0, irq_n}, 8'h00);

        // R1: reset in the middle of activity
        rst = 1'b1;
        @(negedge clk); #1;
        bus_addr = 1'b0; #1 chk("R1 flags after mid reset", bus_rdata, 8'h00);
        bus_addr = 1'b1; #1 chk("R1 mask after mid reset", bus_rdata, 8'h80);
        chk("R1 irq_n after mid reset", {7'd0, irq_n}, 8'h01);
        rst = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule